// File: doc/BRIEF.md
# Two-Row Socket Chip-Select Decoder

This block sits behind a page-mapping stage on a byte-wide memory card with eight sockets, organised as two rows of four. It takes the physical page number and the byte offset inside that page, and turns them into one active-low chip select for the socket that holds the byte. It also produces gated write and output enables. Each row has its own 3-bit chip-size code, so the two rows can carry chips of different sizes. The lower row starts at physical address zero. The upper row follows directly after the last byte of the lower row.

Every output is registered. A select therefore appears on the clock edge after the request is presented. When the wait strap is set, the block raises a single-cycle wait request at the start of each access that hits an enabled page. A power-low input forces every select and the write enable inactive, which protects memory contents while the supply is failing.

Top module: `chip_sel_decoder`

## Requirements
- R1: Row A covers byte addresses 0 up to 4·chipA−1, where addr = {page, offset} and chipA = 16 KB << size_a. Socket k of row A (select bit cs_n[k], k = 0..3) is chosen by the two address bits directly above the chip's own address range, that is addr[15+size_a : 14+size_a].
- R2: Row B starts at 4·chipA. Its local address, addr − 4·chipA, selects socket cs_n[4+k] through bits [15+size_b : 14+size_b].
- R3: An address at or beyond 4·chipA + 4·chipB asserts no select.
- R4: A size code from 100 to 111 means the row is empty and its span is zero. If row A is empty, row B starts at address 0.
- R5: A select is asserted only when hit=1 and rd or wr is 1. When hit=0, no select is asserted.
- R6: When pwr_low=1, all eight selects and we_n are held high.
- R7: oe_n is low exactly when rd and hit are both 1. we_n is low exactly when wr and hit are both 1 and pwr_low is 0.
- R8: With wait_en=1, wait_req is high for exactly one cycle, following the first cycle of an access. An access is a run of cycles with hit and (rd or wr) set. wait_req is never raised on a miss or when wait_en=0.
- R9: All outputs are registered: they update on the clock edge after the inputs. In reset, cs_n is all ones, we_n and oe_n are 1, and wait_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page | input | 7 | Physical page number (16 KB pages) |
| offset | input | 14 | Byte offset within the page |
| hit | input | 1 | The access hits an enabled page |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| size_a | input | 3 | Row A chip-size code (000=16K … 011=128K) |
| size_b | input | 3 | Row B chip-size code |
| wait_en | input | 1 | Wait-state strap |
| pwr_low | input | 1 | Supply below threshold |
| cs_n | output | 8 | Socket selects; bits 3..0 row A, bits 7..4 row B |
| we_n | output | 1 | Gated write enable |
| oe_n | output | 1 | Gated output enable |
| wait_req | output | 1 | Single-cycle wait request |

## Verification
The hardest case to reach is the boundary between the two rows when their sizes differ. At that point the socket index for row B comes from shifted bits of a subtracted address, not from raw address bits. The stimulus sweeps every page across both rows and past the installed total for several size pairs. These include unequal pairs, both extremes and an empty lower row. Wait behaviour is exercised with back-to-back accesses, an idle gap and a miss inside a run.

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder #(
  parameter int PG_W  = 7,
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PG_W-1:0]  page,
  input  logic [OFS_W-1:0] offset,
  input  logic             hit,
  input  logic             rd,
  input  logic             wr,
  input  logic [2:0]       size_a,
  input  logic [2:0]       size_b,
  input  logic             wait_en,
  input  logic             pwr_low,
  output logic [7:0]       cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             wait_req
);
  localparam int AW = PG_W + OFS_W;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] row_span(input logic [2:0] code);
    return code[2] ? '0 : ONE << (OFS_W + 2 + int'(code[1:0]));
  endfunction

  logic [AW-1:0] addr, span_a, end_b, loc_b, idx_a, idx_b;
  logic [7:0]    sel;
  logic          acc, acc_q;

  assign addr   = {page, offset};
  assign span_a = row_span(size_a);
  assign end_b  = span_a + row_span(size_b);
  assign loc_b  = addr - span_a;
  assign idx_a  = addr  >> (OFS_W + int'(size_a[1:0]));
  assign idx_b  = loc_b >> (OFS_W + int'(size_b[1:0]));
  assign acc    = hit && (rd || wr);

  always_comb begin
    sel = '0;
    if (acc && !pwr_low) begin
      if (addr < span_a)     sel[{1'b0, idx_a[1:0]}] = 1'b1;
      else if (addr < end_b) sel[{1'b1, idx_b[1:0]}] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n     <= '1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      wait_req <= 1'b0;
      acc_q    <= 1'b0;
    end else begin
      cs_n     <= ~sel;
      we_n     <= !(wr && hit && !pwr_low);
      oe_n     <= !(rd && hit);
      wait_req <= wait_en && acc && !acc_q;
      acc_q    <= acc;
    end
  end

  p_single_sel_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n) !hit |=> (&cs_n) && !wait_req);
  p_pwr_block_r6:  assert property (@(posedge clk) disable iff (!rst_n) pwr_low |=> (&cs_n) && we_n);
  p_wait_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) wait_req |=> !wait_req);
  p_wait_strap_r8: assert property (@(posedge clk) disable iff (!rst_n) !wait_en |=> !wait_req);
endmodule

// File: tb/sim_chip_sel_decoder.sv
module sim_chip_sel_decoder;
  logic clk = 0, rst_n = 0;
  logic [6:0] page = 0;
  logic [13:0] offset = 0;
  logic hit = 0, rd = 0, wr = 0, wait_en = 0, pwr_low = 0;
  logic [2:0] size_a = 0, size_b = 0;
  logic [7:0] cs_n;
  logic we_n, oe_n, wait_req;
  int checks = 0, fails = 0;
  bit prev_acc = 0, done = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  chip_sel_decoder u0 (.clk(clk), .rst_n(rst_n), .page(page), .offset(offset), .hit(hit),
    .rd(rd), .wr(wr), .size_a(size_a), .size_b(size_b), .wait_en(wait_en),
    .pwr_low(pwr_low), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .wait_req(wait_req));

  function automatic int pages_of(input logic [2:0] c);
    return c[2] ? 0 : (4 << c[1:0]);
  endfunction

  task automatic step(input int pg, input int of, input bit h, r, w, pl, we,
                      input logic [2:0] sa, sb, input string tag);
    logic [7:0] cs;
    int pa, pb;
    bit acc;
    @(negedge clk);
    page = 7'(pg); offset = 14'(of); hit = h; rd = r; wr = w;
    pwr_low = pl; wait_en = we; size_a = sa; size_b = sb;
    cs = 8'hFF;
    pa = pages_of(sa); pb = pages_of(sb);
    acc = h && (r || w);
    if (acc && !pl) begin
      if (pg < pa) cs[pg / (1 << sa[1:0])] = 1'b0;
      else if (pg - pa < pb) cs[4 + (pg - pa) / (1 << sb[1:0])] = 1'b0;
    end
    exp_q.push_back({cs, !(w && h && !pl), !(r && h), we && acc && !prev_acc});
    tag_q.push_back(tag);
    prev_acc = acc;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({cs_n, we_n, oe_n, wait_req} !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, {cs_n, we_n, oe_n, wait_req}, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R9 reset values
    if ({cs_n, we_n, oe_n, wait_req} !== 11'b11111111_110) begin
      fails++;
      $display("FAIL R9 reset: got %b expected %b", {cs_n, we_n, oe_n, wait_req}, 11'b11111111_110);
    end
    rst_n = 1;
    // R1 R2 R3: row A 64K, row B 32K, sweep past the end
    for (int p = 0; p < 28; p++) step(p, 16'h1234 % 16384, 1, 1, 0, 0, 0, 3'b010, 3'b001, "R1/R2/R3 sweep 64K/32K");
    // R1 R2 R3: both rows 16K, total 128 KB
    for (int p = 0; p < 10; p++) step(p, 16383, 1, 0, 1, 0, 0, 3'b000, 3'b000, "R1/R2/R3 sweep 16K/16K");
    // both rows 128K
    for (int p = 28; p < 70; p++) step(p, 0, 1, 1, 0, 0, 0, 3'b011, 3'b011, "R1/R2/R3 sweep 128K/128K");
    // R2 R3: row A 16K, row B 128K
    for (int p = 0; p < 40; p++) step(p, 5, 1, 1, 0, 0, 0, 3'b000, 3'b011, "R2/R3 sweep 16K/128K");
    // R4: empty rows
    step(0, 0, 1, 1, 0, 0, 0, 3'b100, 3'b011, "R4 empty row A, row B at zero");
    step(31, 0, 1, 1, 0, 0, 0, 3'b101, 3'b011, "R4 empty row A, top of row B");
    step(32, 0, 1, 1, 0, 0, 0, 3'b110, 3'b011, "R4 empty row A, beyond row B");
    step(3, 0, 1, 1, 0, 0, 0, 3'b000, 3'b111, "R4 empty row B");
    step(4, 0, 1, 1, 0, 0, 0, 3'b000, 3'b111, "R4 empty row B, nothing above A");
    // R5: miss and no strobe
    step(2, 0, 0, 1, 1, 0, 1, 3'b010, 3'b010, "R5 miss");
    step(2, 0, 1, 0, 0, 0, 1, 3'b010, 3'b010, "R5 no strobe");
    // R6 R7: power low
    step(5, 0, 1, 0, 1, 1, 0, 3'b010, 3'b010, "R6 power low write");
    step(5, 0, 1, 1, 0, 1, 0, 3'b010, 3'b010, "R6/R7 power low read");
    step(5, 0, 1, 0, 1, 0, 0, 3'b010, 3'b010, "R7 write");
    step(5, 0, 1, 1, 1, 0, 0, 3'b010, 3'b010, "R7 read and write");
    step(5, 0, 0, 0, 0, 0, 0, 3'b010, 3'b010, "R7 idle");
    // R8: wait request
    step(1, 0, 1, 1, 0, 0, 1, 3'b010, 3'b010, "R8 first cycle");
    step(1, 0, 1, 1, 0, 0, 1, 3'b010, 3'b010, "R8 second cycle");
    step(1, 0, 1, 1, 0, 0, 1, 3'b010, 3'b010, "R8 third cycle");
    step(1, 0, 0, 1, 0, 0, 1, 3'b010, 3'b010, "R8 miss in run");
    step(9, 0, 1, 0, 1, 0, 1, 3'b010, 3'b010, "R8 new access");
    step(9, 0, 0, 0, 0, 0, 1, 3'b010, 3'b010, "R8 idle");
    step(9, 0, 1, 0, 1, 0, 0, 3'b010, 3'b010, "R8 strap off");
    step(9, 0, 0, 0, 0, 0, 1, 3'b010, 3'b010, "R8 idle again");
    step(9, 0, 1, 0, 1, 1, 1, 3'b010, 3'b010, "R8 wait under power low");
    step(9, 0, 0, 0, 0, 0, 0, 3'b010, 3'b010, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule